// File: doc/BRIEF.md
# Crystal Oscillator Startup Monitor

This block drives the enable of an external high-frequency crystal or resonator oscillator and reports when its output can be trusted. Software stores a frequency-range code and a startup count in a configuration register, then sets the enable bit in a control register. From the enable, the block counts the programmed number of 64 µs intervals. The interval ticks come from dividing the block clock by a parameter. When the count is done, the block raises a clock-good flag.

Clearing the enable stops the oscillator, drops the good flag and resets the timer. A disable is refused while a downstream consumer still depends on the clock. This is the case when the phase-locked loop uses the oscillator as its reference and is not yet reported off, or when the main clock runs from the high-speed path. A refused disable leaves the oscillator running and raises a sticky error flag, which software clears by writing to a third register.

Top module: `xtal_start_mon`

## Requirements
- R1: After reset, osc_en_o, good_o and dis_err_o are 0 and range_o is 0.
- R2: A write with wr_addr_i=1 (control) and wr_data_i[0]=1 while disabled sets osc_en_o at that clock edge. From that edge, range_o shows the range code (wr_data_i[RANGE_W-1:0] of the last write to wr_addr_i=0) that was held when the enable was written.
- R3: For a startup count k>=1 (wr_data_i[RANGE_W +: TIME_W] of the configuration write), good_o rises exactly k*TICK_DIV clock edges after the enabling edge and is 0 before that.
- R4: A startup count of 0 behaves as one tick: good_o rises TICK_DIV edges after the enabling edge.
- R5: good_o is never 1 while osc_en_o is 0.
- R6: A control write with wr_data_i[0]=0 while no interlock is active clears osc_en_o and good_o at that edge. A later enable runs the full startup interval again.
- R7: While pll_ref_i=1 and pll_off_i=0, a disable write is refused: osc_en_o and good_o stay unchanged and dis_err_o is set at that edge.
- R8: While mclk_hs_i=1, a disable write is refused in the same way as in R7, whatever the PLL inputs are.
- R9: With pll_ref_i=1 and pll_off_i=1 and mclk_hs_i=0, a disable write is accepted.
- R10: dis_err_o stays set until a write with wr_addr_i=2 and wr_data_i[0]=1 clears it. A write to that address with wr_data_i[0]=0 leaves it unchanged.
- R11: Configuration writes while enabled do not change range_o or the running startup interval. They take effect at the next enable. While disabled, range_o shows the stored range code.
- R12: An enable write while already enabled does not restart the startup timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the source of the 64 µs tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 configuration, 1 control, 2 error clear |
| wr_data_i | input | RANGE_W+TIME_W | Write data |
| pll_ref_i | input | 1 | PLL takes its reference from the oscillator |
| pll_off_i | input | 1 | PLL reports that it is off |
| mclk_hs_i | input | 1 | Main clock runs from the high-speed path |
| osc_en_o | output | 1 | Oscillator enable |
| range_o | output | RANGE_W | Frequency-range code to the oscillator |
| good_o | output | 1 | Oscillator started and usable |
| dis_err_o | output | 1 | Sticky flag for a refused disable |

## Verification
All outputs are registered. osc_en_o, range_o and dis_err_o answer a write at the same rising edge that samples it. good_o rises k*TICK_DIV edges after the enabling edge. The bench drives inputs and samples outputs on falling edges and counts elapsed edges from each write. It checks good_o one edge before its due edge (it must still be 0) and again on the due edge. The bench shortens TICK_DIV to 4 so that these windows stay short but keep several counts per tick.

// File: rtl/xtal_pkg.sv
package xtal_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CFG = 2'd0,
    SEL_CTL = 2'd1,
    SEL_CLR = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Consumer still needs the clock: disable must be refused
  function automatic logic clk_in_use(logic pll_ref, logic pll_off, logic mclk_hs);
    return (pll_ref && !pll_off) || mclk_hs;
  endfunction
endpackage

// File: rtl/xtal_regs.sv
module xtal_regs
  import xtal_pkg::*;
#(
  parameter int unsigned RANGE_W = 2,
  parameter int unsigned TIME_W  = 8,
  localparam int unsigned DATA_W = RANGE_W + TIME_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               pll_ref_i,
  input  logic               pll_off_i,
  input  logic               mclk_hs_i,
  output logic               en_q_o,
  output logic               en_d_o,
  output logic               start_o,
  output logic [TIME_W-1:0]  time_o,
  output logic [RANGE_W-1:0] range_o,
  output logic               err_o
);
  logic [RANGE_W-1:0] cfg_range_q, act_range_q;
  logic [TIME_W-1:0]  cfg_time_q;
  logic               en_q, err_q;
  logic               wr_cfg, wr_ctl, wr_clr;
  logic               dis_req, refuse, start;
  logic               locked;

  always_comb begin
    wr_cfg  = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_CFG);
    wr_ctl  = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_CTL);
    wr_clr  = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_CLR);
    locked  = clk_in_use(pll_ref_i, pll_off_i, mclk_hs_i);
    start   = wr_ctl && wr_data_i[0] && !en_q;
    dis_req = wr_ctl && !wr_data_i[0] && en_q;
    refuse  = dis_req && locked;
  end

  always_comb begin
    en_d_o = en_q;
    if (start) en_d_o = 1'b1;
    else if (dis_req && !locked) en_d_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      cfg_range_q <= '0;
      cfg_time_q  <= '0;
      act_range_q <= '0;
    end else begin
      en_q <= en_d_o;
      if (wr_cfg) begin
        cfg_range_q <= wr_data_i[RANGE_W-1:0];
        cfg_time_q  <= wr_data_i[RANGE_W +: TIME_W];
      end
      if (start) act_range_q <= cfg_range_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     err_q <= 1'b0;
    else if (refuse)                 err_q <= 1'b1;
    else if (wr_clr && wr_data_i[0]) err_q <= 1'b0;
  end

  assign en_q_o  = en_q;
  assign start_o = start;
  assign time_o  = cfg_time_q;
  assign range_o = en_q ? act_range_q : cfg_range_q;
  assign err_o   = err_q;
endmodule

// File: rtl/xtal_tick_div.sv
module xtal_tick_div #(
  parameter int unsigned TICK_DIV = 3200,
  localparam int unsigned DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/xtal_start_timer.sv
module xtal_start_timer #(
  parameter int unsigned TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_d_i,
  input  logic              start_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              tick_i,
  output logic              good_o
);
  logic [TIME_W-1:0] rem_q;
  logic              good_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      good_q <= 1'b0;
    end else if (!en_d_i) begin
      rem_q  <= '0;
      good_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= time_i;
      good_q <= 1'b0;
    end else if (tick_i && !good_q) begin
      // count of 0 or 1 both finish on the first tick
      if (rem_q <= TIME_W'(1)) good_q <= 1'b1;
      else                     rem_q  <= rem_q - 1'b1;
    end
  end

  assign good_o = good_q;
endmodule

// File: rtl/xtal_start_mon.sv
module xtal_start_mon
  import xtal_pkg::*;
#(
  parameter int unsigned RANGE_W  = 2,
  parameter int unsigned TIME_W   = 8,
  parameter int unsigned TICK_DIV = 3200,
  localparam int unsigned DATA_W  = RANGE_W + TIME_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               pll_ref_i,
  input  logic               pll_off_i,
  input  logic               mclk_hs_i,
  output logic               osc_en_o,
  output logic [RANGE_W-1:0] range_o,
  output logic               good_o,
  output logic               dis_err_o
);
  logic              en_q, en_d, start, tick, good;
  logic [TIME_W-1:0] time_val;

  xtal_regs #(.RANGE_W(RANGE_W), .TIME_W(TIME_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .pll_ref_i (pll_ref_i),
    .pll_off_i (pll_off_i),
    .mclk_hs_i (mclk_hs_i),
    .en_q_o    (en_q),
    .en_d_o    (en_d),
    .start_o   (start),
    .time_o    (time_val),
    .range_o   (range_o),
    .err_o     (dis_err_o)
  );

  xtal_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start || !en_d),
    .run_i  (en_q && !good),
    .tick_o (tick)
  );

  xtal_start_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_d_i  (en_d),
    .start_i (start),
    .time_i  (time_val),
    .tick_i  (tick),
    .good_o  (good)
  );

  assign osc_en_o = en_q;
  assign good_o   = good;
endmodule

// File: rtl/xtal_start_mon_chk.sv
module xtal_start_mon_chk
  import xtal_pkg::*;
#(
  parameter int unsigned RANGE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic               wr_bit0_i,
  input logic               pll_ref_i,
  input logic               pll_off_i,
  input logic               mclk_hs_i,
  input logic               osc_en_o,
  input logic [RANGE_W-1:0] range_o,
  input logic               good_o,
  input logic               dis_err_o
);
  logic in_use, dis_wr;
  assign in_use = (pll_ref_i && !pll_off_i) || mclk_hs_i;
  assign dis_wr = wr_en_i && (wr_addr_i == 2'd1) && !wr_bit0_i;

  p_good_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> osc_en_o);

  p_good_rise_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(good_o) |-> $past(osc_en_o));

  p_hold_when_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && in_use) |=> osc_en_o);

  p_refuse_flags_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_wr && osc_en_o && in_use) |=> dis_err_o);

  p_range_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_en_o && $past(osc_en_o)) |-> $stable(range_o));

  p_dis_drops_good_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> !good_o);
endmodule

bind xtal_start_mon xtal_start_mon_chk #(.RANGE_W(RANGE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_bit0_i (wr_data_i[0]),
  .pll_ref_i (pll_ref_i),
  .pll_off_i (pll_off_i),
  .mclk_hs_i (mclk_hs_i),
  .osc_en_o  (osc_en_o),
  .range_o   (range_o),
  .good_o    (good_o),
  .dis_err_o (dis_err_o)
);

// File: tb/xtal_start_mon_test.sv
`timescale 1ns/1ps
module xtal_start_mon_test;
  localparam int RW = 2;
  localparam int TW = 8;
  localparam int DIV = 4;
  localparam int DW = RW + TW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          pll_ref = 1'b0, pll_off = 1'b1, mclk_hs = 1'b0;
  logic          osc_en, good, dis_err;
  logic [RW-1:0] range;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  xtal_start_mon #(.RANGE_W(RW), .TIME_W(TW), .TICK_DIV(DIV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pll_ref_i(pll_ref), .pll_off_i(pll_off),
    .mclk_hs_i(mclk_hs), .osc_en_o(osc_en), .range_o(range),
    .good_o(good), .dis_err_o(dis_err)
  );

  task automatic check(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic cfg(input int rng, input int tm);
    wr(2'd0, DW'((tm << RW) | rng));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // good must be 0 one edge before due and 1 on the due edge; 'done' edges already elapsed
  task automatic expect_good(input int due, input int done, input string tag);
    wait_cyc(due - done - 1);
    check(good, 0, {tag, " good early"});
    wait_cyc(1);
    check(good, 1, {tag, " good on time"});
  endtask

  task automatic t_reset;
    check(osc_en, 0, "R1 osc_en");
    check(good, 0, "R1 good");
    check(dis_err, 0, "R1 err");
    check(int'(range), 0, "R1 range");
  endtask

  task automatic t_start(input int rng, input int tm);
    cfg(rng, tm);
    check(int'(range), rng, "R11 range shown while off");
    wr(2'd1, DW'(1));
    check(osc_en, 1, "R2 enable");
    check(int'(range), rng, "R2 range latched");
    expect_good(DIV * tm, 0, "R3");
  endtask

  task automatic t_disable_free;
    wr(2'd1, DW'(0));
    check(osc_en, 0, "R6 en off");
    check(good, 0, "R6 good off");
  endtask

  task automatic t_zero;
    cfg(1, 0);
    wr(2'd1, DW'(1));
    expect_good(DIV, 0, "R4");
    t_disable_free();
  endtask

  task automatic t_restart;
    cfg(2, 2);
    wr(2'd1, DW'(1));
    wait_cyc(3);
    t_disable_free();
    wr(2'd1, DW'(1));
    expect_good(2 * DIV, 0, "R6 full restart");
    t_disable_free();
  endtask

  task automatic t_pll_lock;
    cfg(0, 1);
    wr(2'd1, DW'(1));
    wait_cyc(DIV);
    pll_ref = 1'b1; pll_off = 1'b0;
    wr(2'd1, DW'(0));
    check(osc_en, 1, "R7 en kept");
    check(good, 1, "R7 good kept");
    check(dis_err, 1, "R7 err set");
    pll_off = 1'b1;
    wr(2'd2, DW'(0));
    check(dis_err, 1, "R10 clear with bit0=0 ignored");
    wr(2'd2, DW'(1));
    check(dis_err, 0, "R10 cleared");
    wr(2'd1, DW'(0));
    check(osc_en, 0, "R9 pll off disable accepted");
    check(dis_err, 0, "R9 no err");
    pll_ref = 1'b0;
  endtask

  task automatic t_mclk_lock;
    wr(2'd1, DW'(1));
    mclk_hs = 1'b1; pll_ref = 1'b1; pll_off = 1'b1;
    wr(2'd1, DW'(0));
    check(osc_en, 1, "R8 en kept");
    check(dis_err, 1, "R8 err set");
    wait_cyc(2);
    check(dis_err, 1, "R10 sticky");
    mclk_hs = 1'b0; pll_ref = 1'b0;
    wr(2'd2, DW'(1));
    t_disable_free();
  endtask

  task automatic t_cfg_frozen;
    cfg(1, 2);
    wr(2'd1, DW'(1));
    cfg(3, 5);
    check(int'(range), 1, "R11 range frozen");
    expect_good(2 * DIV, 1, "R11 old time");
    t_disable_free();
    check(int'(range), 3, "R11 new range when off");
    wr(2'd1, DW'(1));
    check(int'(range), 3, "R11 new range used");
    expect_good(5 * DIV, 0, "R11 new time");
    t_disable_free();
  endtask

  task automatic t_re_enable;
    cfg(0, 3);
    wr(2'd1, DW'(1));
    wait_cyc(DIV + 1);
    wr(2'd1, DW'(1));
    expect_good(3 * DIV, DIV + 2, "R12 no restart");
    t_disable_free();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    wait_cyc(3);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_start(2, 3);
    t_disable_free();
    t_zero();
    t_restart();
    t_pll_lock();
    t_mclk_lock();
    t_cfg_frozen();
    t_re_enable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule